// File: doc/BRIEF.md
# Multiprocessor Asynchronous Serial Transceiver

This block is a full-duplex asynchronous serial transceiver. Transmit words enter through a valid/ready port into a one-word holding register. When the transmit shift register is idle, the held word moves into it and is shifted out on `txd`. The frame is a low start bit, the data bits least significant first, an optional parity bit, and one or two high stop bits. The receiver samples `rxd` against the same oversampling tick. It places each completed word in a one-word receive buffer, which a valid/ready port drains.

A reload counter followed by a divide-by-2 or divide-by-3 prescaler produces the oversampling tick. One bit lasts 16 ticks. Words are 8 or 9 bits wide. When 9-bit mode and address-only reception are both on, the receiver drops any word whose top bit is 0. Only frames marked as addresses reach the buffer, which suits a multidrop bus. A loopback switch routes the transmit stream into the receiver and parks `txd` high. Four pulse outputs report the following events:
- transmit holding register emptied
- final stop bit started
- receive buffer filled
- error (with three separate pulses naming the cause)

Back-pressure rules: a transmit word is taken on a clock where `tx_valid` and `tx_ready` are both high. While `tx_valid` waits, `tx_data` must stay unchanged. `rx_valid` stays high with `rx_data` unchanged until a clock where `rx_ready` is high. If a new frame completes while the buffer is still unread, the new frame is lost, not the buffered one.

Top module: `sercom_mp`

## Requirements
- R1: One bit lasts 16 oversampling ticks. A tick occurs every (`cfg_reload`+1)×(`cfg_div3` ? 3 : 2) clocks. The frame order on the line is start (0), data least significant bit first, parity if enabled, then stop bits (1).
- R2: With `cfg_nine`=0 a frame carries 8 data bits and `rx_data[8]` reads 0. With `cfg_nine`=1 it carries all 9 bits of the word.
- R3: When `cfg_par_en`=1, the parity bit follows the data. It makes the count of ones in data plus parity even when `cfg_par_odd`=0 and odd when `cfg_par_odd`=1. A received parity mismatch pulses `err_parity` and `irq_err`, and the word is still stored.
- R4: `tx_ready` is high exactly while the holding register is empty. A word can be accepted while the shifter is busy. The move from holding register to shifter pulses `irq_tx_empty` for one clock.
- R5: `irq_tx_last` pulses for one clock as the final stop bit begins. `cfg_two_stop`=1 sends two stop bits, 0 sends one.
- R6: A completed receive frame is stored in the buffer, raises `rx_valid` and pulses `irq_rx_full`. `rx_valid` falls after a clock with `rx_ready` high.
- R7: A stop bit sampled low pulses `err_frame` and `irq_err`.
- R8: If a frame completes while `rx_valid` is high and `rx_ready` is low, `err_overrun` and `irq_err` pulse and the buffered word is kept.
- R9: With `cfg_nine`=1 and `cfg_addr_only`=1, a frame whose bit 8 is 0 is discarded: no `rx_valid`, no interrupt, no error. A frame whose bit 8 is 1 is received normally.
- R10: With `cfg_loopback`=1, `txd` stays 1 and the receiver takes the transmit stream, ignoring `rxd`.
- R11: A start needs a falling edge followed by a majority-low vote of ticks 7, 8 and 9. A low pulse shorter than three ticks starts no frame.
- R12: After reset `txd`=1, `tx_ready`=1, `rx_valid`=0 and all pulse outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_reload | input | 13 | Baud counter reload value |
| cfg_div3 | input | 1 | Prescaler: 1 divides by 3, 0 by 2 |
| cfg_nine | input | 1 | 9-bit words |
| cfg_par_en | input | 1 | Parity enable |
| cfg_par_odd | input | 1 | Odd parity select |
| cfg_two_stop | input | 1 | Two stop bits |
| cfg_addr_only | input | 1 | Keep only address frames (9-bit mode) |
| cfg_loopback | input | 1 | Internal loopback |
| tx_valid | input | 1 | Transmit word offered |
| tx_data | input | 9 | Transmit word |
| tx_ready | output | 1 | Holding register empty |
| rx_valid | output | 1 | Receive buffer full |
| rx_data | output | 9 | Received word |
| rx_ready | input | 1 | Consumer takes the word |
| rxd | input | 1 | Serial input |
| txd | output | 1 | Serial output |
| irq_tx_empty | output | 1 | Holding register emptied pulse |
| irq_tx_last | output | 1 | Final stop bit started pulse |
| irq_rx_full | output | 1 | Receive buffer filled pulse |
| irq_err | output | 1 | Any receive error pulse |
| err_frame | output | 1 | Framing error pulse |
| err_parity | output | 1 | Parity error pulse |
| err_overrun | output | 1 | Overrun pulse |

## Verification
The assertions rely on three things about the inputs. `tx_data` holds steady while `tx_valid` waits for `tx_ready`. The configuration changes only while both directions are idle. Frames on `rxd` use the bit time that the configuration selects. The bench keeps `tx_valid` and `tx_data` fixed until the handshake clock. Before every configuration change it drains the transmitter and waits out the receiver. It drives `rxd` only with frames built at the configured bit time, apart from one deliberately short glitch. Overrun, address filtering and loopback are reached only through the ports.

// File: rtl/sercom_mp_pkg.sv
package sercom_mp_pkg;
  localparam int OSR     = 16;
  localparam int TW      = $clog2(OSR);
  localparam int MAXD    = 9;
  localparam int FRAME_W = 1 + MAXD + 1 + 2;

  // parity bit that makes data plus parity even (odd when odd=1)
  function automatic logic par_bit(input logic [MAXD-1:0] d, input logic nine, input logic odd);
    par_bit = ^(nine ? d : {1'b0, d[7:0]}) ^ odd;
  endfunction
endpackage

// File: rtl/sercom_mp_baud.sv
module sercom_mp_baud #(
  parameter int RW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [RW-1:0] reload,
  input  logic          div3,
  output logic          tick
);
  logic [RW-1:0] cnt;
  logic [1:0]    pc;
  logic          wrap, plast;

  assign wrap  = (cnt == '0);
  assign plast = div3 ? (pc == 2'd2) : (pc == 2'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      pc   <= '0;
      tick <= 1'b0;
    end else begin
      tick <= 1'b0;
      if (wrap) begin
        cnt <= reload;
        if (plast) begin
          pc   <= '0;
          tick <= 1'b1;
        end else begin
          pc <= pc + 2'd1;
        end
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  // prescaler divides by at least 2, so ticks never touch
  assert_tick_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/sercom_mp_tx.sv
module sercom_mp_tx
  import sercom_mp_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            nine,
  input  logic            par_en,
  input  logic            par_odd,
  input  logic            two_stop,
  input  logic            in_valid,
  input  logic [MAXD-1:0] in_data,
  output logic            in_ready,
  output logic            line,
  output logic            irq_empty,
  output logic            irq_last
);
  logic               hold_full, busy, load;
  logic [MAXD-1:0]    hold;
  logic [FRAME_W-1:0] sh, frame;
  logic [3:0]         nleft, flen, pos;
  logic [TW-1:0]      tcnt;

  always_comb begin
    frame    = '1;
    frame[0] = 1'b0;
    pos      = 4'd1;
    for (int i = 0; i < MAXD; i++) begin
      if (i < 8 || nine) begin
        frame[pos] = hold[i];
        pos        = pos + 4'd1;
      end
    end
    if (par_en) begin
      frame[pos] = par_bit(hold, nine, par_odd);
      pos        = pos + 4'd1;
    end
    flen = pos + 4'd1 + {3'b0, two_stop};
  end

  assign in_ready = !hold_full;
  assign load     = !busy && hold_full;
  assign line     = busy ? sh[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_full <= 1'b0;
      hold      <= '0;
      busy      <= 1'b0;
      sh        <= '1;
      nleft     <= '0;
      tcnt      <= '0;
      irq_empty <= 1'b0;
      irq_last  <= 1'b0;
    end else begin
      irq_empty <= 1'b0;
      irq_last  <= 1'b0;
      if (in_valid && in_ready) begin
        hold      <= in_data;
        hold_full <= 1'b1;
      end
      if (load) begin
        hold_full <= 1'b0;
        sh        <= frame;
        nleft     <= flen;
        tcnt      <= '0;
        busy      <= 1'b1;
        irq_empty <= 1'b1;
      end else if (busy && tick) begin
        tcnt <= tcnt + 1'b1;
        if (tcnt == TW'(OSR-1)) begin
          sh    <= {1'b1, sh[FRAME_W-1:1]};
          nleft <= nleft - 4'd1;
          if (nleft == 4'd2) irq_last <= 1'b1;
          if (nleft == 4'd1) busy <= 1'b0;
        end
      end
    end
  end

  assert_in_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !in_ready |=> in_valid && $stable(in_data));
  assert_load_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_empty |=> busy);
  assert_last_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_last |-> line && busy);
endmodule

// File: rtl/sercom_mp_rx.sv
module sercom_mp_rx
  import sercom_mp_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            nine,
  input  logic            par_en,
  input  logic            par_odd,
  input  logic            addr_only,
  input  logic            line_in,
  output logic            out_valid,
  output logic [MAXD-1:0] out_data,
  input  logic            out_ready,
  output logic            irq_full,
  output logic            err_frame,
  output logic            err_par,
  output logic            err_ovr
);
  typedef enum logic {RX_IDLE, RX_RUN} rx_st_t;
  rx_st_t          st;
  logic            prev, s7, s8, pbit, maj, keep, par_bad;
  logic [TW-1:0]   tcnt;
  logic [3:0]      bidx, nd;
  logic [MAXD-1:0] data;

  assign nd      = nine ? 4'd9 : 4'd8;
  assign maj     = (s7 & s8) | (s7 & line_in) | (s8 & line_in);
  assign keep    = !(addr_only && nine && !data[8]);
  assign par_bad = par_en && (pbit != par_bit(data, nine, par_odd));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= RX_IDLE;
      prev      <= 1'b1;
      s7        <= 1'b1;
      s8        <= 1'b1;
      pbit      <= 1'b0;
      tcnt      <= '0;
      bidx      <= '0;
      data      <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      irq_full  <= 1'b0;
      err_frame <= 1'b0;
      err_par   <= 1'b0;
      err_ovr   <= 1'b0;
    end else begin
      irq_full  <= 1'b0;
      err_frame <= 1'b0;
      err_par   <= 1'b0;
      err_ovr   <= 1'b0;
      prev      <= line_in;
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (st == RX_IDLE) begin
        if (prev && !line_in) begin
          st   <= RX_RUN;
          tcnt <= '0;
          bidx <= '0;
          data <= '0;
        end
      end else if (tick) begin
        tcnt <= tcnt + 1'b1;
        if (tcnt == TW'(7)) s7 <= line_in;
        if (tcnt == TW'(8)) s8 <= line_in;
        if (tcnt == TW'(9)) begin
          if (bidx == 4'd0) begin
            if (maj) st <= RX_IDLE;
          end else if (bidx <= nd) begin
            data[bidx - 4'd1] <= maj;
          end else if (par_en && bidx == nd + 4'd1) begin
            pbit <= maj;
          end else begin
            st <= RX_IDLE;
            if (keep) begin
              err_frame <= !maj;
              err_par   <= par_bad;
              if (out_valid && !out_ready) begin
                err_ovr <= 1'b1;
              end else begin
                out_data  <= data;
                out_valid <= 1'b1;
                irq_full  <= 1'b1;
              end
            end
          end
        end
        if (tcnt == TW'(OSR-1)) bidx <= bidx + 4'd1;
      end
    end
  end

  assert_full_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_full |-> out_valid);
  assert_ovr_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_ovr |-> out_valid && $stable(out_data));
  assert_ovr_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_full |-> !err_ovr);
endmodule

// File: rtl/sercom_mp.sv
module sercom_mp
  import sercom_mp_pkg::*;
#(
  parameter int RELOAD_W = 13
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [RELOAD_W-1:0] cfg_reload,
  input  logic                cfg_div3,
  input  logic                cfg_nine,
  input  logic                cfg_par_en,
  input  logic                cfg_par_odd,
  input  logic                cfg_two_stop,
  input  logic                cfg_addr_only,
  input  logic                cfg_loopback,
  input  logic                tx_valid,
  input  logic [MAXD-1:0]     tx_data,
  output logic                tx_ready,
  output logic                rx_valid,
  output logic [MAXD-1:0]     rx_data,
  input  logic                rx_ready,
  input  logic                rxd,
  output logic                txd,
  output logic                irq_tx_empty,
  output logic                irq_tx_last,
  output logic                irq_rx_full,
  output logic                irq_err,
  output logic                err_frame,
  output logic                err_parity,
  output logic                err_overrun
);
  logic tick, tx_line, rx_in;
  logic [1:0] rsync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync <= 2'b11;
    else        rsync <= {rsync[0], rxd};
  end

  assign rx_in   = cfg_loopback ? tx_line : rsync[1];
  assign txd     = cfg_loopback ? 1'b1 : tx_line;
  assign irq_err = err_frame | err_parity | err_overrun;

  sercom_mp_baud #(.RW(RELOAD_W)) u_baud (
    .clk(clk), .rst_n(rst_n), .reload(cfg_reload), .div3(cfg_div3), .tick(tick)
  );

  sercom_mp_tx u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .nine(cfg_nine), .par_en(cfg_par_en), .par_odd(cfg_par_odd), .two_stop(cfg_two_stop),
    .in_valid(tx_valid), .in_data(tx_data), .in_ready(tx_ready),
    .line(tx_line), .irq_empty(irq_tx_empty), .irq_last(irq_tx_last)
  );

  sercom_mp_rx u_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .nine(cfg_nine), .par_en(cfg_par_en), .par_odd(cfg_par_odd), .addr_only(cfg_addr_only),
    .line_in(rx_in), .out_valid(rx_valid), .out_data(rx_data), .out_ready(rx_ready),
    .irq_full(irq_rx_full), .err_frame(err_frame), .err_par(err_parity), .err_ovr(err_overrun)
  );
endmodule

// File: tb/sercom_mp_bench.sv
module sercom_mp_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [12:0] cfg_reload = '0;
  logic cfg_div3 = 0, cfg_nine = 0, cfg_par_en = 0, cfg_par_odd = 0;
  logic cfg_two_stop = 0, cfg_addr_only = 0, cfg_loopback = 0;
  logic tx_valid = 0, rx_ready = 0, rxd = 1'b1;
  logic [8:0] tx_data = '0;
  logic tx_ready, rx_valid, txd, irq_tx_empty, irq_tx_last, irq_rx_full, irq_err;
  logic err_frame, err_parity, err_overrun;
  logic [8:0] rx_data;

  sercom_mp u_sercom_mp (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  int n_empty = 0, n_last = 0, n_full = 0, n_err = 0, n_fe = 0, n_pe = 0, n_ov = 0;
  int last_cyc = 0, lb_bad = 0, bitclk = 32, pclk = 2;
  bit mon_act = 0, done = 0;
  logic [15:0] txq[$];
  int lenq[$];

  always @(posedge clk) cyc <= cyc + 1;

  // per-clock observation of the pulse outputs and the loopback line
  always @(negedge clk) if (rst_n) begin
    if (irq_tx_empty) n_empty++;
    if (irq_tx_last) begin n_last++; last_cyc = cyc; end
    if (irq_rx_full) n_full++;
    if (irq_err) n_err++;
    if (err_frame) n_fe++;
    if (err_parity) n_pe++;
    if (err_overrun) n_ov++;
    if (cfg_loopback && txd !== 1'b1) lb_bad++;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int mk_frame(input logic [8:0] d, output logic [15:0] f);
    int n = 0;
    int nd = cfg_nine ? 9 : 8;
    bit p = cfg_par_odd;
    f = '1;
    f[n] = 1'b0; n++;
    for (int i = 0; i < nd; i++) begin f[n] = d[i]; p ^= d[i]; n++; end
    if (cfg_par_en) begin f[n] = p; n++; end
    f[n] = 1'b1; n++;
    if (cfg_two_stop) begin f[n] = 1'b1; n++; end
    return n;
  endfunction

  task automatic set_rate(input int reload, input bit d3);
    cfg_reload = 13'(reload);
    cfg_div3 = d3;
    pclk = (reload + 1) * (d3 ? 3 : 2);
    bitclk = 16 * pclk;
  endtask

  task automatic tx_send(input logic [8:0] d, input bit expect_line);
    logic [15:0] f;
    int n;
    @(negedge clk);
    tx_valid = 1'b1;
    tx_data = d;
    if (expect_line) begin n = mk_frame(d, f); txq.push_back(f); lenq.push_back(n); end
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  // line monitor: decodes txd at mid-bit and compares with the expected frame queue
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && !cfg_loopback && txd === 1'b0) begin
        logic [15:0] exp_f, got;
        int len, t0;
        mon_act = 1;
        t0 = cyc;
        got = '1;
        exp_f = txq.size() ? txq.pop_front() : 16'h0;
        len = lenq.size() ? lenq.pop_front() : 1;
        repeat (bitclk/2) @(negedge clk);
        for (int k = 0; k < len; k++) begin
          got[k] = txd;
          if (k < len - 1) repeat (bitclk) @(negedge clk);
        end
        check(got == exp_f, "R1 frame bits on txd", int'(got), int'(exp_f));
        check(last_cyc - t0 <= (len-1)*bitclk && last_cyc - t0 > (len-1)*bitclk - pclk,
              "R5 final stop pulse timing", last_cyc - t0, (len-1)*bitclk);
        mon_act = 0;
      end
    end
  end

  task automatic wait_tx_done();
    while (txq.size() != 0 || mon_act) @(negedge clk);
    repeat (bitclk) @(negedge clk);
  endtask

  task automatic rx_drive(input logic [8:0] d, input bit flip_par, input bit bad_stop);
    int nd = cfg_nine ? 9 : 8;
    bit p = cfg_par_odd;
    @(negedge clk);
    rxd = 1'b0; repeat (bitclk) @(negedge clk);
    for (int i = 0; i < nd; i++) begin rxd = d[i]; p ^= d[i]; repeat (bitclk) @(negedge clk); end
    if (cfg_par_en) begin rxd = p ^ flip_par; repeat (bitclk) @(negedge clk); end
    rxd = !bad_stop; repeat (bitclk) @(negedge clk);
    rxd = 1'b1; repeat (2*bitclk) @(negedge clk);
  endtask

  task automatic rx_take(input logic [8:0] exp_d, input string req);
    check(rx_valid === 1'b1, req, int'(rx_valid), 1);
    check(rx_data === exp_d, req, int'(rx_data), int'(exp_d));
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
    check(rx_valid === 1'b0, "R6 buffer released after read", int'(rx_valid), 0);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=%0d expected=done", cyc);
      summary();
    end
  end

  initial begin
    int e0, f0, ov0, fe0, pe0, er0;
    set_rate(0, 0);
    repeat (3) @(negedge clk);
    // R12 reset state
    check(txd === 1'b1 && tx_ready === 1'b1 && rx_valid === 1'b0, "R12 reset outputs",
          int'({txd, tx_ready, rx_valid}), 3'b110);
    check({irq_tx_empty, irq_tx_last, irq_rx_full, irq_err} === 4'b0, "R12 reset pulses",
          int'({irq_tx_empty, irq_tx_last, irq_rx_full, irq_err}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R4 double buffer, 8 data bits, one stop
    e0 = n_empty;
    tx_send(9'h0A5, 1);
    tx_send(9'h03C, 1);
    check(tx_ready === 1'b0, "R4 holding register full while shifter busy", int'(tx_ready), 0);
    wait_tx_done();
    check(n_empty - e0 == 2, "R4 empty pulse per transfer", n_empty - e0, 2);
    check(n_last == 2, "R5 last-bit pulse per frame", n_last, 2);

    // R1 R2 R3 R5: slower rate, 9 bits, odd parity, two stops
    set_rate(1, 1);
    cfg_nine = 1; cfg_par_en = 1; cfg_par_odd = 1; cfg_two_stop = 1;
    tx_send(9'h1B7, 1);
    tx_send(9'h020, 1);
    wait_tx_done();
    set_rate(0, 0);
    cfg_nine = 0; cfg_par_odd = 0; cfg_two_stop = 0;

    // R3 R6 receive with even parity, good frame
    f0 = n_full; er0 = n_err;
    rx_drive(9'h037, 0, 0);
    check(n_full - f0 == 1, "R6 full pulse", n_full - f0, 1);
    check(n_err == er0, "R3 no error on matching parity", n_err - er0, 0);
    rx_take(9'h037, "R6 received word");

    // R3 parity error, word still stored
    pe0 = n_pe; er0 = n_err;
    rx_drive(9'h0C1, 1, 0);
    check(n_pe - pe0 == 1 && n_err - er0 == 1, "R3 parity error pulse", n_pe - pe0, 1);
    rx_take(9'h0C1, "R3 word kept on parity error");
    cfg_par_en = 0;

    // R7 framing error
    fe0 = n_fe; er0 = n_err;
    rx_drive(9'h05A, 0, 1);
    check(n_fe - fe0 == 1 && n_err - er0 == 1, "R7 framing error pulse", n_fe - fe0, 1);
    rx_take(9'h05A, "R7 word with bad stop");

    // R8 overrun keeps the first word
    ov0 = n_ov; f0 = n_full;
    rx_drive(9'h011, 0, 0);
    rx_drive(9'h022, 0, 0);
    check(n_ov - ov0 == 1, "R8 overrun pulse", n_ov - ov0, 1);
    check(n_full - f0 == 1, "R8 no full pulse for lost frame", n_full - f0, 1);
    rx_take(9'h011, "R8 first word kept");

    // R9 R2 address-only filtering in 9-bit mode
    cfg_nine = 1; cfg_addr_only = 1;
    f0 = n_full; er0 = n_err;
    rx_drive(9'h0A5, 0, 0);
    check(rx_valid === 1'b0 && n_full == f0 && n_err == er0, "R9 data frame discarded",
          int'(rx_valid), 0);
    rx_drive(9'h1C3, 0, 0);
    rx_take(9'h1C3, "R9 R2 address frame received with bit 8");
    cfg_addr_only = 0;
    rx_drive(9'h0A5, 0, 0);
    rx_take(9'h0A5, "R2 nine-bit data frame without filter");
    cfg_nine = 0;

    // R11 short low glitch starts nothing
    f0 = n_full; er0 = n_err;
    @(negedge clk); rxd = 1'b0;
    repeat (4) @(negedge clk); rxd = 1'b1;
    repeat (20*bitclk) @(negedge clk);
    check(rx_valid === 1'b0 && n_full == f0 && n_err == er0, "R11 glitch rejected",
          int'(rx_valid), 0);

    // R10 loopback: rxd held low is ignored, txd stays high
    cfg_loopback = 1;
    repeat (2) @(negedge clk);
    rxd = 1'b0;
    tx_send(9'h06D, 0);
    repeat (12*bitclk) @(negedge clk);
    rx_take(9'h06D, "R10 loopback word");
    check(lb_bad == 0, "R10 txd idle in loopback", lb_bad, 0);
    rxd = 1'b1;
    repeat (4) @(negedge clk);
    cfg_loopback = 0;
    repeat (4) @(negedge clk);

    done = 1;
    summary();
  end
endmodule